// File: doc/BRIEF.md
# Sync Character Strip Filter

This block sits between a receive shift register and the receive FIFO and CRC checker of a serial receiver. Each assembled byte arrives with a one-cycle valid strobe. The block decides whether that byte is written into the FIFO, and so whether it is fed to the CRC. When stripping is enabled, bytes equal to a programmed compare value are suppressed. The decision depends on the framing mode (asynchronous, monosync, bisync or SDLC) and on a short-sync option.

In monosync with the short-sync option, a run of sync bytes is reduced to the single sync byte that comes just before the data. To do this the block holds every byte for one byte time. A held byte is released when the next byte arrives, and a held sync byte is dropped if that next byte is also a sync. A byte that is written to the FIFO is always fed to the CRC, and a suppressed byte never is. Both strobes are single-cycle pulses that line up with the output data.

Top module: `sync_strip_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_stb` and `crc_stb` are 0 and `wr_byte` is 0.
- R2: With `strip_en` low, every byte accepted on `in_vld` appears on `wr_byte` in the cycle after it is accepted, with `wr_stb` and `crc_stb` high, in every mode.
- R3: Mode encoding is 0 asynchronous, 1 monosync, 2 bisync, 3 SDLC. In monosync and bisync with `six_bit_sync` low and `strip_en` high, a byte equal to `sync_cmp` produces no strobe, and any other byte passes in the next cycle.
- R4: In asynchronous mode with `strip_en` high, a byte equal to `sync_cmp` is suppressed, whatever the value of `six_bit_sync`.
- R5: In SDLC mode `strip_en` has no effect, and every byte passes in the next cycle.
- R6: In bisync with `six_bit_sync` high, `strip_en` has no effect, and every byte passes in the next cycle.
- R7: The compare uses all eight bits. A byte that differs from `sync_cmp` only in bit 6 or bit 7 is not treated as a sync, and this holds in the short-sync monosync case as well.
- R8: In monosync with `strip_en` and `six_bit_sync` high, each byte is held until the next valid byte arrives. In the cycle after that arrival the held byte is written, unless both the held byte and the new byte equal `sync_cmp`. As a result, only the last sync before data survives.
- R9: `crc_stb` is high in exactly the cycles in which `wr_stb` is high, and each strobe lasts one cycle for each byte written.
- R10: When the short-sync monosync configuration is left, a byte still held is discarded and is never written.
- R11: `wr_stb` is high only in the cycle after a cycle with `in_vld` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | One-cycle strobe: `in_byte` holds an assembled byte |
| in_byte | input | 8 | Byte from the receive shift register |
| sync_cmp | input | 8 | Programmed sync compare value |
| strip_en | input | 1 | Enables suppression of bytes that match |
| mode | input | 2 | Framing mode: 0 async, 1 monosync, 2 bisync, 3 SDLC |
| six_bit_sync | input | 1 | Short-sync option |
| wr_stb | output | 1 | FIFO write strobe |
| wr_byte | output | 8 | Byte to be written into the FIFO |
| crc_stb | output | 1 | Strobe that includes `wr_byte` in the CRC |

## Verification
Every output is registered once. A byte that is accepted at a clock edge therefore shows its result, whether a strobe or no strobe, in the cycle right after that edge. In the short-sync monosync configuration, that result belongs to the previously held byte, not to the one just accepted. The bench drives inputs on the falling edge and keeps `in_vld` high for exactly one rising edge. It then samples the outputs on the next falling edge, so every check sees the cycle in which the result is due. Held-byte cases are checked one byte time late by sending the follow-up byte first.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
   typedef enum logic [1:0] {
      MODE_ASYNC  = 2'd0,
      MODE_MONO   = 2'd1,
      MODE_BISYNC = 2'd2,
      MODE_SDLC   = 2'd3
   } ssf_mode_e;
endpackage

// File: rtl/ssf_policy.sv
module ssf_policy
   import ssf_pkg::*;
#(
   parameter bit KEEP_LAST = 1'b1
) (
   input  logic [1:0] mode_i,
   input  logic       strip_en_i,
   input  logic       six_i,
   output logic       strip_on_o,
   output logic       defer_on_o
);
   ssf_mode_e mode_s;
   logic      short_mono;

   assign mode_s = ssf_mode_e'(mode_i);

   always_comb begin
      strip_on_o = strip_en_i
                 && (mode_s != MODE_SDLC)
                 && !((mode_s == MODE_BISYNC) && six_i);
      short_mono = six_i && (mode_s == MODE_MONO);
   end

   generate
      if (KEEP_LAST) begin : g_keep
         assign defer_on_o = strip_on_o && short_mono;
      end else begin : g_nokeep
         assign defer_on_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ssf_match.sv
module ssf_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              eq_o
);
   logic [DATA_W-1:0] bit_eq;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_bit
         assign bit_eq[gi] = ~(a_i[gi] ^ b_i[gi]);
      end
   endgenerate

   assign eq_o = &bit_eq;
endmodule

// File: rtl/ssf_defer.sv
module ssf_defer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              defer_on_i,
   input  logic              in_vld_i,
   input  logic [DATA_W-1:0] in_byte_i,
   input  logic              in_sync_i,
   output logic              emit_o,
   output logic [DATA_W-1:0] emit_byte_o
);
   logic              slot_vld;
   logic              slot_sync;
   logic [DATA_W-1:0] slot_byte;

   always_ff @(posedge clk) begin
      if (!rst_n || !defer_on_i) begin
         slot_vld  <= 1'b0;
         slot_sync <= 1'b0;
         slot_byte <= '0;
      end else if (in_vld_i) begin
         slot_vld  <= 1'b1;
         slot_sync <= in_sync_i;
         slot_byte <= in_byte_i;
      end
   end

   always_comb begin
      emit_o      = defer_on_i && in_vld_i && slot_vld && !(slot_sync && in_sync_i);
      emit_byte_o = slot_byte;
   end
endmodule

// File: rtl/sync_strip_filter.sv
module sync_strip_filter #(
   parameter int DATA_W    = 8,
   parameter bit KEEP_LAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_byte,
   input  logic [DATA_W-1:0] sync_cmp,
   input  logic              strip_en,
   input  logic [1:0]        mode,
   input  logic              six_bit_sync,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_byte,
   output logic              crc_stb
);
   localparam int MIN_W = 6;

   generate
      if (DATA_W < MIN_W) begin : g_width_bad
         $error("sync_strip_filter: DATA_W must be at least %0d", MIN_W);
      end
   endgenerate

   logic              strip_on;
   logic              defer_on;
   logic              in_sync;
   logic              d_emit;
   logic [DATA_W-1:0] d_byte;
   logic              nxt_stb;
   logic [DATA_W-1:0] nxt_byte;

   ssf_policy #(.KEEP_LAST(KEEP_LAST)) u_policy (
      .mode_i     (mode),
      .strip_en_i (strip_en),
      .six_i      (six_bit_sync),
      .strip_on_o (strip_on),
      .defer_on_o (defer_on)
   );

   ssf_match #(.DATA_W(DATA_W)) u_match (
      .a_i  (in_byte),
      .b_i  (sync_cmp),
      .eq_o (in_sync)
   );

   ssf_defer #(.DATA_W(DATA_W)) u_defer (
      .clk         (clk),
      .rst_n       (rst_n),
      .defer_on_i  (defer_on),
      .in_vld_i    (in_vld),
      .in_byte_i   (in_byte),
      .in_sync_i   (in_sync),
      .emit_o      (d_emit),
      .emit_byte_o (d_byte)
   );

   always_comb begin
      if (defer_on) begin
         nxt_stb  = d_emit;
         nxt_byte = d_byte;
      end else begin
         nxt_stb  = in_vld && !(strip_on && in_sync);
         nxt_byte = in_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         crc_stb <= 1'b0;
         wr_byte <= '0;
      end else begin
         wr_stb  <= nxt_stb;
         crc_stb <= nxt_stb;
         if (nxt_stb) wr_byte <= nxt_byte;
      end
   end
endmodule

// File: rtl/sync_strip_filter_chk.sv
module sync_strip_filter_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [DATA_W-1:0] in_byte,
   input logic [DATA_W-1:0] sync_cmp,
   input logic              strip_en,
   input logic [1:0]        mode,
   input logic              six_bit_sync,
   input logic              wr_stb,
   input logic [DATA_W-1:0] wr_byte,
   input logic              crc_stb
);
   // R2
   pass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !strip_en) |=> (wr_stb && crc_stb && wr_byte == $past(in_byte)));

   // R3
   mono_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && strip_en && mode == 2'd1 && !six_bit_sync && in_byte == sync_cmp) |=> !wr_stb);

   // R5
   sdlc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && mode == 2'd3) |=> (wr_stb && wr_byte == $past(in_byte)));

   // R6
   bisync_short_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && mode == 2'd2 && six_bit_sync) |=> (wr_stb && wr_byte == $past(in_byte)));

   // R11
   stb_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !wr_stb);
endmodule

bind sync_strip_filter sync_strip_filter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_vld       (in_vld),
   .in_byte      (in_byte),
   .sync_cmp     (sync_cmp),
   .strip_en     (strip_en),
   .mode         (mode),
   .six_bit_sync (six_bit_sync),
   .wr_stb       (wr_stb),
   .wr_byte      (wr_byte),
   .crc_stb      (crc_stb)
);

// File: tb/sync_strip_filter_tb.sv
module sync_strip_filter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_vld = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic [7:0] sync_cmp = 8'h00;
   logic       strip_en = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       six_bit_sync = 1'b0;
   logic       wr_stb;
   logic [7:0] wr_byte;
   logic       crc_stb;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_strip_filter u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
      .sync_cmp(sync_cmp), .strip_en(strip_en), .mode(mode),
      .six_bit_sync(six_bit_sync), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .crc_stb(crc_stb)
   );

   // {mode, strip_en, six, cmp, din, exp_stb, exp_byte}
   localparam logic [28:0] VEC [0:NVEC-1] = '{
      {2'd1, 1'b0, 1'b0, 8'h16, 8'h16, 1'b1, 8'h16},  // R2
      {2'd0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b1, 8'h3C},  // R2
      {2'd1, 1'b1, 1'b0, 8'h16, 8'h16, 1'b0, 8'h00},  // R3
      {2'd1, 1'b1, 1'b0, 8'h16, 8'h17, 1'b1, 8'h17},  // R3
      {2'd2, 1'b1, 1'b0, 8'h32, 8'h32, 1'b0, 8'h00},  // R3
      {2'd0, 1'b1, 1'b0, 8'h0D, 8'h0D, 1'b0, 8'h00},  // R4
      {2'd0, 1'b1, 1'b1, 8'h0D, 8'h0D, 1'b0, 8'h00},  // R4
      {2'd3, 1'b1, 1'b0, 8'h7E, 8'h7E, 1'b1, 8'h7E},  // R5
      {2'd3, 1'b1, 1'b1, 8'h7E, 8'h7E, 1'b1, 8'h7E},  // R5
      {2'd2, 1'b1, 1'b1, 8'h32, 8'h32, 1'b1, 8'h32},  // R6
      {2'd1, 1'b1, 1'b0, 8'h16, 8'h56, 1'b1, 8'h56},  // R7
      {2'd0, 1'b1, 1'b0, 8'h16, 8'hD6, 1'b1, 8'hD6},  // R7
      {2'd2, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b1, 8'hA5}   // R2
   };

   task automatic check(input string req, input logic exp_stb, input logic [7:0] exp_byte);
      total++;
      if (wr_stb !== exp_stb || crc_stb !== exp_stb ||
          (exp_stb && wr_byte !== exp_byte)) begin
         bad++;
         $display("FAIL %s: wr_stb=%0b crc_stb=%0b wr_byte=%02h expected stb=%0b byte=%02h",
                  req, wr_stb, crc_stb, wr_byte, exp_stb, exp_byte);
      end
   endtask

   // starts and ends at a falling edge
   task automatic send(input logic [7:0] b);
      in_vld  = 1'b1;
      in_byte = b;
      @(negedge clk);
      in_vld  = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic en, input logic six, input logic [7:0] c);
      mode = m; strip_en = en; six_bit_sync = six; sync_cmp = c;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 8'h00);
      total++;
      if (wr_byte !== 8'h00) begin
         bad++;
         $display("FAIL R1: wr_byte=%02h expected 00", wr_byte);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0, 8'h00);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         set_cfg(VEC[i][28:27], VEC[i][26], VEC[i][25], VEC[i][24:17]);
         send(VEC[i][16:9]);
         check($sformatf("vector %0d (R2..R7)", i), VEC[i][8], VEC[i][7:0]);
         @(negedge clk);
         check($sformatf("vector %0d pulse width R9", i), 1'b0, 8'h00);
      end

      // R11: idle with a matching byte on the data lines
      set_cfg(2'd0, 1'b0, 1'b0, 8'h11);
      in_byte = 8'h11;
      repeat (3) @(negedge clk);
      check("R11 idle", 1'b0, 8'h00);

      // R8: short-sync monosync keeps last sync before data
      set_cfg(2'd1, 1'b1, 1'b1, 8'h16);
      @(negedge clk);
      send(8'h16); check("R8 first sync held", 1'b0, 8'h00);
      send(8'h16); check("R8 sync dropped", 1'b0, 8'h00);
      send(8'h16); check("R8 sync dropped", 1'b0, 8'h00);
      send(8'h41); check("R8 last sync released", 1'b1, 8'h16);
      @(negedge clk); check("R9 single pulse", 1'b0, 8'h00);
      send(8'h42); check("R8 data released", 1'b1, 8'h41);
      send(8'h16); check("R8 data before sync", 1'b1, 8'h42);
      send(8'h43); check("R8 lone sync kept", 1'b1, 8'h16);
      send(8'h56); check("R8 data", 1'b1, 8'h43);
      send(8'h16); check("R7 top-bit variant not a sync", 1'b1, 8'h56);
      send(8'h96); check("R7 bit7 variant breaks sync run", 1'b1, 8'h16);

      // R10: leave configuration with a byte held
      send(8'h16); check("R8 held before switch", 1'b1, 8'h96);
      set_cfg(2'd1, 1'b1, 1'b0, 8'h16);
      repeat (2) @(negedge clk);
      check("R10 no stray write", 1'b0, 8'h00);
      send(8'h20); check("R10 held byte discarded", 1'b1, 8'h20);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule